// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

A four-bit register with four single-bit outputs, QA at one end and QD at the other. Two mode bits choose what happens on each rising clock edge. The register can keep its value, shift toward QD, shift toward QA, or load four parallel data bits. Each shift direction has its own serial input. The input that feeds the QA end is used when shifting toward QD. The input that feeds the QD end is used when shifting toward QA.

An active-low clear empties the register at once, whatever the clock is doing. Normal operation resumes on the first rising edge after clear is released. Every port is a separate single-bit signal. The block is meant as a building element for serial arithmetic and data-path staging. Each parallel input maps to the output of the same letter.

Top module: `usr_shift4`

## Requirements
- R1: While rst_ni is low, q_a_o, q_b_o, q_c_o and q_d_o are all 0 at once, regardless of clock, mode or data inputs.
- R2: With rst_ni high, the outputs change only on a rising edge of clk_i. After rst_ni rises, the first rising edge performs the selected operation.
- R3: Mode {mode_hi_i,mode_lo_i}=11 loads q_a_o..q_d_o from par_a_i..par_d_i on the edge.
- R4: Mode 01 shifts toward QD: QA takes ser_qa_i, QB takes old QA, QC takes old QB, QD takes old QC.
- R5: Mode 10 shifts toward QA: QA takes old QB, QB takes old QC, QC takes old QD, QD takes ser_qd_i.
- R6: Mode 00 keeps all four outputs unchanged across clock edges, whatever the data and serial inputs do.
- R7: In both shift modes the parallel inputs have no effect on the result. In load mode both serial inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| mode_hi_i | input | 1 | Mode select, upper bit |
| mode_lo_i | input | 1 | Mode select, lower bit |
| ser_qa_i | input | 1 | Serial input entering at QA (shift toward QD) |
| ser_qd_i | input | 1 | Serial input entering at QD (shift toward QA) |
| par_a_i | input | 1 | Parallel data for QA |
| par_b_i | input | 1 | Parallel data for QB |
| par_c_i | input | 1 | Parallel data for QC |
| par_d_i | input | 1 | Parallel data for QD |
| q_a_o | output | 1 | Register bit A |
| q_b_o | output | 1 | Register bit B |
| q_c_o | output | 1 | Register bit C |
| q_d_o | output | 1 | Register bit D |

## Verification
The register has no hidden state beyond its four bits, so a wrong bit is visible at the outputs one cycle after the edge that wrote it. A swapped neighbour or a wrong serial source shows as a wrong bit after a single shift. A value that sits in the wrong place moves out through the end bits within four further shifts, which is why each load is followed by four shifts in each direction. A wrong clear or hold shows before the next edge and at it.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MD_HOLD = 2'b00,
    MD_SHR  = 2'b01,
    MD_SHL  = 2'b10,
    MD_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
  import usr_pkg::*;
(
  input  logic      sel_hi_i,
  input  logic      sel_lo_i,
  output usr_mode_e mode_o
);
  always_comb begin
    case ({sel_hi_i, sel_lo_i})
      2'b01:   mode_o = MD_SHR;
      2'b10:   mode_o = MD_SHL;
      2'b11:   mode_o = MD_LOAD;
      default: mode_o = MD_HOLD;  // 00 or unknown select keeps contents
    endcase
  end
endmodule

// File: rtl/usr_next.sv
module usr_next
  import usr_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  usr_mode_e    mode_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] par_i,
  input  logic         ser_lo_i,   // enters bit 0 when shifting up
  input  logic         ser_hi_i,   // enters bit W-1 when shifting down
  output logic [W-1:0] d_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_lo, from_hi;
    if (i == 0) begin : g_first
      assign from_lo = ser_lo_i;
    end else begin : g_mid_lo
      assign from_lo = q_i[i-1];
    end
    if (i == W - 1) begin : g_last
      assign from_hi = ser_hi_i;
    end else begin : g_mid_hi
      assign from_hi = q_i[i+1];
    end
    always_comb begin
      case (mode_i)
        MD_SHR:  d_o[i] = from_lo;
        MD_SHL:  d_o[i] = from_hi;
        MD_LOAD: d_o[i] = par_i[i];
        default: d_o[i] = q_i[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_shift4.sv
module usr_shift4
  import usr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_hi_i,
  input  logic mode_lo_i,
  input  logic ser_qa_i,
  input  logic ser_qd_i,
  input  logic par_a_i,
  input  logic par_b_i,
  input  logic par_c_i,
  input  logic par_d_i,
  output logic q_a_o,
  output logic q_b_o,
  output logic q_c_o,
  output logic q_d_o
);
  localparam int unsigned W = 4;

  usr_mode_e    mode;
  logic [W-1:0] par, q_r, d;

  assign par = {par_d_i, par_c_i, par_b_i, par_a_i};  // bit 0 is QA

  usr_mode_dec u_dec (
    .sel_hi_i (mode_hi_i),
    .sel_lo_i (mode_lo_i),
    .mode_o   (mode)
  );

  usr_next #(.W(W)) u_next (
    .mode_i   (mode),
    .q_i      (q_r),
    .par_i    (par),
    .ser_lo_i (ser_qa_i),
    .ser_hi_i (ser_qd_i),
    .d_o      (d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= '0;
    else         q_r <= d;
  end

  assign q_a_o = q_r[0];
  assign q_b_o = q_r[1];
  assign q_c_o = q_r[2];
  assign q_d_o = q_r[3];

  p_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> ({q_d_o, q_c_o, q_b_o, q_a_o} == 4'b0000));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_hi_i && mode_lo_i) |=>
      ({q_d_o, q_c_o, q_b_o, q_a_o} == $past({par_d_i, par_c_i, par_b_i, par_a_i})));

  p_shr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_hi_i && mode_lo_i) |=>
      ({q_d_o, q_c_o, q_b_o, q_a_o} == $past({q_c_o, q_b_o, q_a_o, ser_qa_i})));

  p_shl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_hi_i && !mode_lo_i) |=>
      ({q_d_o, q_c_o, q_b_o, q_a_o} == $past({ser_qd_i, q_d_o, q_c_o, q_b_o})));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_hi_i && !mode_lo_i) |=> $stable({q_d_o, q_c_o, q_b_o, q_a_o}));
endmodule

// File: tb/sim_usr_shift4.sv
module sim_usr_shift4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_hi = 1'b0, m_lo = 1'b0, s_qa = 1'b0, s_qd = 1'b0;
  logic [3:0] par = 4'h0;  // bit 0 drives A
  logic qa, qb, qc, qd;
  logic [3:0] exp_q = 4'h0;  // bit 0 is QA
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  usr_shift4 u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_hi_i(m_hi), .mode_lo_i(m_lo),
    .ser_qa_i(s_qa), .ser_qd_i(s_qd),
    .par_a_i(par[0]), .par_b_i(par[1]), .par_c_i(par[2]), .par_d_i(par[3]),
    .q_a_o(qa), .q_b_o(qb), .q_c_o(qc), .q_d_o(qd)
  );

  task automatic check(input string req);
    logic [3:0] act;
    act = {qd, qc, qb, qa};
    checks++;
    if (act !== exp_q) begin
      errors++;
      $display("FAIL %s: q(DCBA)=%b expected %b at %0t", req, act, exp_q, $time);
    end
  endtask

  // mode: 0 hold, 1 toward QD, 2 toward QA, 3 load
  task automatic step(input int mode, input logic [3:0] p, input logic sa,
                      input logic sd, input string req);
    @(negedge clk);
    m_hi = mode[1]; m_lo = mode[0]; par = p; s_qa = sa; s_qd = sd;
    @(posedge clk);
    #1;
    case (mode)
      1: exp_q = ((exp_q << 1) | {3'b000, sa}) & 4'hF;
      2: exp_q = (exp_q >> 1) | ({3'b000, sd} << 3);
      3: exp_q = p;
      default: ;
    endcase
    check(req);
  endtask

  initial begin
    #2;
    check("R1 reset");
    #20 rst_n = 1'b1;
    for (int v = 0; v < 16; v++) begin
      step(3, 4'(v), ~v[0], ~v[1], "R3 load");
      for (int k = 0; k < 4; k++)
        step(1, ~4'(v), v[k], ~v[k], "R4/R7 shift toward QD");
      step(3, 4'(v), 1'b1, 1'b1, "R3 reload");
      for (int k = 0; k < 4; k++)
        step(2, ~4'(v) ^ 4'(k), ~v[k], v[k], "R5/R7 shift toward QA");
      step(0, ~4'(v), 1'b1, 1'b0, "R6 hold");
      step(0, 4'(v) ^ 4'h5, 1'b0, 1'b1, "R6 hold");
    end
    // R7: serial inputs must not disturb a load
    step(3, 4'hA, 1'b1, 1'b1, "R7 load vs serial high");
    step(3, 4'h5, 1'b0, 1'b0, "R7 load vs serial low");
    // R2: mid-cycle input changes leave outputs alone until the edge
    @(negedge clk);
    m_hi = 1'b1; m_lo = 1'b1; par = 4'hC;
    #1 check("R2 no change between edges");
    @(posedge clk); #1; exp_q = 4'hC; check("R2 change at edge");
    // R1: asynchronous clear mid-cycle
    @(negedge clk); #1 rst_n = 1'b0;
    #1 exp_q = 4'h0; check("R1 async clear");
    @(posedge clk); #1 check("R1 clear held over edge");
    @(negedge clk); rst_n = 1'b1;
    step(3, 4'h9, 1'b0, 1'b0, "R2 first edge after clear");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule